// File: doc/BRIEF.md
# E3 All-Ones Alarm Monitor

This block watches the serial bit stream of an E3 receiver and decides whether the line carries an all-ones Alarm Indication Signal. A framer outside this block supplies a one-cycle strobe at the first bit of every frame. The monitor counts the zero bits that arrive between strobes. At each strobe it classifies the frame that has just ended as either alarm-like or clean. A run of consecutive frames of the opposite kind is needed to change the alarm state, and this rule applies both to raising the alarm and to dropping it.

The alarm state drives a dedicated output pin. It can also be read live through a small register read port. Every change of the alarm state, in either direction, latches a change flag. Reading the interrupt status address returns the flag and clears it. An interrupt request line follows the flag, gated by an enable input. Frame alignment, loss-of-signal detection and any other alarm are handled elsewhere.

Top module: `e3_ais_monitor`

## Requirements
- R1: Zero bits are counted only in cycles with `bit_valid` high. The bit presented with `frame_start` belongs to the new frame. A frame with 7 or fewer zeros is alarm-like, and a frame with 8 or more zeros is clean. The count saturates at 8.
- R2: The alarm is declared after 2 consecutive alarm-like frames. `ais_pin` rises two clock edges after the `frame_start` that closes the second such frame.
- R3: The alarm is cleared after 2 consecutive clean frames, with the same two-edge latency.
- R4: A single frame of the other kind restarts the run, and the alarm state does not change.
- R5: Every change of the alarm state sets the change flag one edge after the state changes. A read of address 0x14 returns that flag in bit 1, and all other bits read zero.
- R6: A read of address 0x14 clears the flag after returning it. If a new change arrives in the same cycle as the read, the flag stays set.
- R7: `irq` is high exactly when the flag is set and `irq_en` was high at the same edge.
- R8: A read of address 0x11 returns the live alarm state in bit 3, and all other bits read zero. A read of any other address returns zero. `rd_data` is valid one edge after `rd_en` and is zero in cycles after an edge with no read.
- R9: After reset the alarm, the flag, `irq` and `rd_data` are all zero. The first `frame_start` after reset opens a frame and does not classify one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Received data bit |
| bit_valid | input | 1 | `rx_bit` carries a line bit this cycle |
| frame_start | input | 1 | One-cycle strobe at the first bit of a frame |
| irq_en | input | 1 | Enable for the interrupt request line |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Registered read data |
| ais_pin | output | 1 | High while the alarm is declared |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that reset is held on the first clock edge. They also assume that `frame_start` is a single-cycle pulse and that at least one cycle separates two pulses, so that every classification is consumed before the next one arrives. The stimulus sends frames built from a chosen zero count, with zeros placed at the head of the frame and idle gaps in which `bit_valid` is low. It keeps every frame longer than the two-edge decision pipeline, and it issues reads only in single-cycle strobes.

// File: rtl/e3ais_pkg.sv
package e3ais_pkg;
  localparam int unsigned ADDR_W = 8;
  typedef logic [ADDR_W-1:0] addr_t;
  localparam addr_t ADDR_LIVE_STAT = 8'h11;
  localparam addr_t ADDR_CHG_STAT  = 8'h14;
  localparam int unsigned BIT_LIVE_AIS = 3;
  localparam int unsigned BIT_CHG_AIS  = 1;
endpackage

// File: rtl/e3ais_zero_count.sv
module e3ais_zero_count #(
  parameter int unsigned ZERO_LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_bit,
  input  logic bit_valid,
  input  logic frame_start,
  output logic ev_valid,
  output logic ev_ais_like
);
  localparam int unsigned CNT_W = $clog2(ZERO_LIMIT + 1);

  logic [CNT_W-1:0] zcnt;
  logic             primed;
  logic             new_zero;

  assign new_zero = bit_valid & ~rx_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      zcnt        <= '0;
      primed      <= 1'b0;
      ev_valid    <= 1'b0;
      ev_ais_like <= 1'b0;
    end else begin
      ev_valid    <= frame_start & primed;
      ev_ais_like <= (zcnt < CNT_W'(ZERO_LIMIT));
      if (frame_start) begin
        primed <= 1'b1;
        zcnt   <= new_zero ? CNT_W'(1) : '0;
      end else if (new_zero && (zcnt != CNT_W'(ZERO_LIMIT))) begin
        zcnt <= zcnt + CNT_W'(1);
      end
    end
  end

  // R1: count never passes the saturation point
  a_r1_cnt_sat: assert property (@(posedge clk) disable iff (rst)
    zcnt <= CNT_W'(ZERO_LIMIT));
  // R9: no classification before the first strobe after reset
  a_r9_no_eval_unprimed: assert property (@(posedge clk) disable iff (rst)
    !primed |=> !ev_valid);
endmodule

// File: rtl/e3ais_hyst.sv
module e3ais_hyst #(
  parameter int unsigned CONSEC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ev_valid,
  input  logic ev_ais_like,
  output logic ais,
  output logic chg
);
  localparam int unsigned RUN_W = $clog2(CONSEC + 1);

  logic [RUN_W-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      ais <= 1'b0;
      chg <= 1'b0;
      run <= '0;
    end else begin
      chg <= 1'b0;
      if (ev_valid) begin
        if (ev_ais_like != ais) begin
          if (run == RUN_W'(CONSEC - 1)) begin
            ais <= ~ais;
            run <= '0;
            chg <= 1'b1;
          end else begin
            run <= run + RUN_W'(1);
          end
        end else begin
          run <= '0;
        end
      end
    end
  end

  // R2: alarm only rises right after an alarm-like frame
  a_r2_rise_after_ais_frame: assert property (@(posedge clk) disable iff (rst)
    $rose(ais) |-> $past(ev_valid && ev_ais_like));
  // R3: alarm only falls right after a clean frame
  a_r3_fall_after_clean_frame: assert property (@(posedge clk) disable iff (rst)
    $fell(ais) |-> $past(ev_valid && !ev_ais_like));
  // R4: run counter stays below the threshold
  a_r4_run_bounded: assert property (@(posedge clk) disable iff (rst)
    run < RUN_W'(CONSEC));
  // R5: change pulse coincides with a state toggle
  a_r5_chg_on_toggle: assert property (@(posedge clk) disable iff (rst)
    chg |-> (ais != $past(ais)));
endmodule

// File: rtl/e3ais_regs.sv
module e3ais_regs
  import e3ais_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ais,
  input  logic              chg,
  input  logic              irq_en,
  input  logic              rd_en,
  input  addr_t             rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic flag;
  logic rd_chg;
  logic flag_nxt;

  assign rd_chg   = rd_en && (rd_addr == ADDR_CHG_STAT);
  assign flag_nxt = chg | (flag & ~rd_chg);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag    <= 1'b0;
      irq     <= 1'b0;
      rd_data <= '0;
    end else begin
      flag    <= flag_nxt;
      irq     <= flag_nxt & irq_en;
      rd_data <= '0;
      if (rd_en) begin
        case (rd_addr)
          ADDR_CHG_STAT:  rd_data[BIT_CHG_AIS]  <= flag;
          ADDR_LIVE_STAT: rd_data[BIT_LIVE_AIS] <= ais;
          default:        rd_data <= '0;
        endcase
      end
    end
  end

  // R5: a change event always leaves the flag set
  a_r5_chg_sets_flag: assert property (@(posedge clk) disable iff (rst)
    chg |=> flag);
  // R6: a read with no competing change clears the flag
  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_chg && !chg) |=> !flag);
  // R7: request needs the enable
  a_r7_irq_needs_en: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_en));
  // R8: quiet read port after an edge with no read
  a_r8_quiet_bus: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == '0));
endmodule

// File: rtl/e3_ais_monitor.sv
module e3_ais_monitor
  import e3ais_pkg::*;
#(
  parameter int unsigned ZERO_LIMIT = 8,
  parameter int unsigned CONSEC     = 2,
  parameter int unsigned DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_bit,
  input  logic              bit_valid,
  input  logic              frame_start,
  input  logic              irq_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              ais_pin,
  output logic              irq
);
  logic ev_valid;
  logic ev_ais_like;
  logic ais;
  logic chg;

  e3ais_zero_count #(.ZERO_LIMIT(ZERO_LIMIT)) u_count (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .bit_valid(bit_valid),
    .frame_start(frame_start), .ev_valid(ev_valid), .ev_ais_like(ev_ais_like)
  );

  e3ais_hyst #(.CONSEC(CONSEC)) u_hyst (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_ais_like(ev_ais_like),
    .ais(ais), .chg(chg)
  );

  e3ais_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .ais(ais), .chg(chg), .irq_en(irq_en),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  assign ais_pin = ais;

  // R2: pin leaves reset low and rises only on a classification result
  a_r2_pin_rise_on_eval: assert property (@(posedge clk) disable iff (rst)
    $rose(ais_pin) |-> $past(ev_valid));
endmodule

// File: tb/e3_ais_monitor_tb.sv
module e3_ais_monitor_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_bit = 1'b1;
  logic       bit_valid = 1'b0;
  logic       frame_start = 1'b0;
  logic       irq_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_addr = 8'h00;
  logic [7:0] rd_data;
  logic       ais_pin;
  logic       irq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit rand_reads = 1'b0;

  always #4 clk = ~clk;

  e3_ais_monitor u_dut (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .bit_valid(bit_valid),
    .frame_start(frame_start), .irq_en(irq_en), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .ais_pin(ais_pin), .irq(irq)
  );

  // Behavioural reference model
  int  m_zc, m_run;
  bit  m_primed, m_ais, m_flag, m_chg, m_evv, m_evais, m_irq;
  logic [7:0] m_rd;

  always @(posedge clk) begin
    bit n_flag, n_chg, n_evv, n_evais;
    if (rst) begin
      m_zc = 0; m_run = 0; m_primed = 0; m_ais = 0; m_flag = 0;
      m_chg = 0; m_evv = 0; m_evais = 0; m_irq = 0; m_rd = 8'h00;
    end else begin
      n_flag = m_chg || (m_flag && !(rd_en && rd_addr == 8'h14));
      m_rd = 8'h00;
      if (rd_en && rd_addr == 8'h14) m_rd[1] = m_flag;
      if (rd_en && rd_addr == 8'h11) m_rd[3] = m_ais;
      m_irq = n_flag && irq_en;
      n_chg = 0;
      if (m_evv) begin
        if (m_evais != m_ais) begin
          m_run = m_run + 1;
          if (m_run == 2) begin m_ais = !m_ais; m_run = 0; n_chg = 1; end
        end else m_run = 0;
      end
      n_evv = 0; n_evais = 0;
      if (frame_start) begin
        n_evv = m_primed;
        n_evais = (m_zc <= 7);
        m_primed = 1;
        m_zc = (bit_valid && !rx_bit) ? 1 : 0;
      end else if (bit_valid && !rx_bit && m_zc < 8) m_zc = m_zc + 1;
      m_flag = n_flag; m_chg = n_chg; m_evv = n_evv; m_evais = n_evais;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 R3 R4 ais_pin", int'(ais_pin), int'(m_ais));
      chk("R7 irq", int'(irq), int'(m_irq));
      chk("R5 R6 R8 rd_data", int'(rd_data), int'(m_rd));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic send_frame(int zeros, int len, bit gaps);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      frame_start = (i == 0);
      bit_valid = 1'b1;
      rx_bit = (i < zeros) ? 1'b0 : 1'b1;
      if (rand_reads) begin
        rd_en = ($urandom % 5 == 0);
        case ($urandom % 3)
          0: rd_addr = 8'h11;
          1: rd_addr = 8'h14;
          default: rd_addr = 8'h03;
        endcase
      end
      // R1: an idle cycle carrying a zero must not be counted
      if (gaps && (i % 4 == 1)) begin
        @(negedge clk);
        frame_start = 1'b0; bit_valid = 1'b0; rx_bit = 1'b0; rd_en = 1'b0;
      end
    end
    @(negedge clk);
    frame_start = 1'b0; bit_valid = 1'b0; rx_bit = 1'b1; rd_en = 1'b0;
  endtask

  task automatic read_reg(logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset ais_pin", int'(ais_pin), 0);
    chk("R9 reset irq", int'(irq), 0);
    chk("R9 reset rd_data", int'(rd_data), 0);
    irq_en = 1'b1;
    // R9: first strobe opens a frame; all-ones frames then declare
    send_frame(0, 24, 1'b0);
    send_frame(7, 24, 1'b1);          // R1: 7 zeros, with idle zero gaps
    send_frame(20, 24, 1'b0);
    chk("R1 R2 declared after two alarm-like frames", int'(ais_pin), 1);
    chk("R7 irq after declare", int'(irq), 1);
    send_frame(3, 24, 1'b0);          // R4: breaks clean run of one
    send_frame(8, 24, 1'b0);
    chk("R4 single clean frame keeps alarm", int'(ais_pin), 1);
    send_frame(8, 24, 1'b1);
    send_frame(0, 24, 1'b0);
    chk("R1 R3 cleared after two clean frames", int'(ais_pin), 0);
    read_reg(8'h14, v);
    chk("R5 change flag bit1", int'(v), 2);
    chk("R7 irq dropped after read", int'(irq), 0);
    read_reg(8'h14, v);
    chk("R6 flag cleared by read", int'(v), 0);
    read_reg(8'h11, v);
    chk("R8 live bit3 clear", int'(v), 0);
    send_frame(1, 24, 1'b0);
    send_frame(0, 24, 1'b0);
    irq_en = 1'b0;
    read_reg(8'h11, v);
    chk("R8 live bit3 set", int'(v), 8);
    chk("R7 irq masked by enable", int'(irq), 0);
    read_reg(8'h03, v);
    chk("R8 other address reads zero", int'(v), 0);
    // random phase, compared every cycle against the model
    rand_reads = 1'b1;
    for (int f = 0; f < 150; f++) begin
      int z;
      irq_en = $urandom % 2;
      case ($urandom % 4)
        0: z = $urandom % 3;
        1: z = 6 + $urandom % 4;
        2: z = 7 + $urandom % 2;
        default: z = 12 + $urandom % 10;
      endcase
      send_frame(z, 14 + $urandom % 16, $urandom % 2);
    end
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule